// File: doc/BRIEF.md
# Parallel I/O Port Controller

This block manages a bank of general-purpose pins from a small memory-mapped register bus. Each pin either belongs to the controller, which drives it from its own output data and output-enable masks and samples it as an input, or is lent to one of two peripheral functions, which then drive the pad and receive its input level. Software changes every configuration mask through paired write-one-to-set and write-one-to-clear offsets and reads it back at a third offset, so no read-modify-write sequence is ever needed.

Pad inputs pass through a two-flop synchronizer before the controller compares them with the last sampled level. A change on a controller-owned pin that is not driving accumulates in an interrupt status word. The status word clears when it is read, and a masked copy of it drives one level-sensitive interrupt line. Each pad also reports whether it is floating. A floating pin reads back as its pull-up enable bit. The input filter and multi-driver masks are only stored and read back.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the ownership mask reads all ones. The output-enable, filter, multi-driver, pull-up, select, direct-write, interrupt mask, interrupt status and output data registers read zero. Every pin starts as floating, and irq_o is low.
- R2: Only the low 9 bits of addr_i are decoded, so every offset aliases with a period of 0x200. A read at an offset that is not listed (including an unaligned one) returns zero. A write to such an offset changes no register and no output.
- R3: The following masks each have a set offset, a clear offset and a status offset: ownership (0x000/0x004/0x008), output enable (0x010/0x014/0x018), input filter (0x020/0x024/0x028), multi-driver (0x050/0x054/0x058), direct-write enable (0x0A0/0x0A4/0x0A8) and interrupt mask (0x040/0x044/0x048). Ones in the written value set or clear the matching bits. Zeros leave the bits unchanged.
- R4: For the pull-up mask, 0x060 clears bits, 0x064 sets bits and 0x068 reads the mask. For the peripheral select mask, 0x070 clears bits (peripheral A), 0x074 sets bits (peripheral B) and 0x078 reads the mask.
- R5: Ones written to 0x030 set output data bits and ones written to 0x034 clear them. Output data reads back at 0x038. The drive level of a pin changes only for bits that are both controller-owned and output-enabled at the time of the write.
- R6: A write to 0x038 replaces only the output data bits, and the drive-level bits, that are set in the direct-write mask. All other bits keep their value.
- R7: On an owned pin, pad_o shows the drive level and pad_oe_o shows the output-enable bit. On a pin that is not owned, a select bit of 0 passes through the data and enable of peripheral A, and a select bit of 1 passes through those of peripheral B.
- R8: A pad level reaches the sampled state three clock edges after it is applied. Pins whose output enable is set ignore input changes. On an owned input pin, a change of the sampled level sets that pin's interrupt status bit.
- R9: A read at 0x03C returns the sampled level for pins known to be driven and the pull-up bit for floating pins. A floating pin is sampled as level 0, so a floating pin that becomes driven high raises an event.
- R10: irq_o is high exactly when some bit is set in both the interrupt status and the interrupt mask.
- R11: A read at 0x04C returns the accumulated status, then clears it. An event sampled on the same edge as that clear survives, so no event is lost.
- R12: For a pin that is not owned and not output-enabled, the synchronized pad level goes to per_a_in_o when the select bit is 0 and to per_b_in_o when the select bit is 1. All other bits of these two outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | BUS_AW | Byte address, decoded modulo 0x200 |
| wdata_i | input | NUM_PINS | Write data, one bit per pin |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe; a status read clears on this edge |
| rdata_o | output | NUM_PINS | Read data, valid in the same cycle as re_i |
| irq_o | output | 1 | Level interrupt |
| pad_i | input | NUM_PINS | Pad input levels |
| pad_unk_i | input | NUM_PINS | Per-pad floating indication |
| pad_o | output | NUM_PINS | Pad drive levels |
| pad_oe_o | output | NUM_PINS | Pad drive enables |
| per_a_dat_i | input | NUM_PINS | Peripheral A drive levels |
| per_a_oe_i | input | NUM_PINS | Peripheral A drive enables |
| per_b_dat_i | input | NUM_PINS | Peripheral B drive levels |
| per_b_oe_i | input | NUM_PINS | Peripheral B drive enables |
| per_a_in_o | output | NUM_PINS | Pad levels forwarded to peripheral A |
| per_b_in_o | output | NUM_PINS | Pad levels forwarded to peripheral B |

## Verification
The checker watches rules that hold on every cycle:
- the drive level never moves on a pin that is not owned and output-enabled during a set or clear write;
- sampled levels stay frozen on output-enabled pins;
- status bits rise only where an event occurred, and every event lands in the status word even during a clearing read;
- a write to an unlisted offset leaves the state unchanged;
- the interrupt stays quiet while the mask is empty.

Only the bench scenarios can show read values against a reference model:
- how floating pins fall back to pull-ups;
- the three-edge input latency;
- the pad and peripheral routing after a change of ownership or select;
- the exact cycle in which a clearing read and a new event coincide.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int WIN_AW    = 9;
  localparam int NUM_MASKS = 8;

  localparam int MK_OWN = 0;
  localparam int MK_OE  = 1;
  localparam int MK_FLT = 2;
  localparam int MK_MD  = 3;
  localparam int MK_WEN = 4;
  localparam int MK_IRQ = 5;
  localparam int MK_PU  = 6;
  localparam int MK_SEL = 7;

  localparam logic [WIN_AW-1:0] OFS_SET [NUM_MASKS] =
    '{9'h000, 9'h010, 9'h020, 9'h050, 9'h0A0, 9'h040, 9'h064, 9'h074};
  localparam logic [WIN_AW-1:0] OFS_CLR [NUM_MASKS] =
    '{9'h004, 9'h014, 9'h024, 9'h054, 9'h0A4, 9'h044, 9'h060, 9'h070};
  localparam logic [WIN_AW-1:0] OFS_STS [NUM_MASKS] =
    '{9'h008, 9'h018, 9'h028, 9'h058, 9'h0A8, 9'h048, 9'h068, 9'h078};

  localparam logic [WIN_AW-1:0] OFS_DSET = 9'h030;
  localparam logic [WIN_AW-1:0] OFS_DCLR = 9'h034;
  localparam logic [WIN_AW-1:0] OFS_DDAT = 9'h038;
  localparam logic [WIN_AW-1:0] OFS_PINS = 9'h03C;
  localparam logic [WIN_AW-1:0] OFS_ISR  = 9'h04C;
endpackage

// File: rtl/gpio_mask_reg.sv
module gpio_mask_reg #(
  parameter int W        = 32,
  parameter bit RST_ONES = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] set_bits, clr_bits;
  assign set_bits = set_i ? val_i : '0;
  assign clr_bits = clr_i ? val_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= {W{RST_ONES}};
    else         q_o <= (q_o | set_bits) & ~clr_bits;
  end
endmodule

// File: rtl/gpio_in_sample.sv
module gpio_in_sample #(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pad_i,
  input  logic [N-1:0] unk_i,
  input  logic [N-1:0] own_i,
  input  logic [N-1:0] oe_i,
  output logic [N-1:0] sync_o,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] unk_o,
  output logic [N-1:0] evt_o
);
  logic [N-1:0] lvl_s1, lvl_s2, unk_s1, unk_s2;
  logic [N-1:0] upd, new_lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_s1 <= '0;
      lvl_s2 <= '0;
      unk_s1 <= '1;
      unk_s2 <= '1;
    end else begin
      lvl_s1 <= pad_i;
      lvl_s2 <= lvl_s1;
      unk_s1 <= unk_i;
      unk_s2 <= unk_s1;
    end
  end

  // floating pads sample as 0; driving pins ignore their pad
  assign upd     = own_i & ~oe_i;
  assign new_lvl = lvl_s2 & ~unk_s2;
  assign evt_o   = upd & (new_lvl ^ lvl_o);
  assign sync_o  = lvl_s2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_o <= '0;
      unk_o <= '1;
    end else begin
      lvl_o <= (lvl_o & ~upd) | (new_lvl & upd);
      unk_o <= (unk_o & ~upd) | (unk_s2 & upd);
    end
  end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int N = 32
) (
  input  logic [N-1:0] own_i,
  input  logic [N-1:0] oe_i,
  input  logic [N-1:0] sel_i,
  input  logic [N-1:0] drv_i,
  input  logic [N-1:0] sync_i,
  input  logic [N-1:0] pa_dat_i,
  input  logic [N-1:0] pa_oe_i,
  input  logic [N-1:0] pb_dat_i,
  input  logic [N-1:0] pb_oe_i,
  output logic [N-1:0] pad_o,
  output logic [N-1:0] pad_oe_o,
  output logic [N-1:0] pa_in_o,
  output logic [N-1:0] pb_in_o
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic fwd;
    assign fwd         = ~own_i[i] & ~oe_i[i] & sync_i[i];
    assign pad_o[i]    = own_i[i] ? drv_i[i] : (sel_i[i] ? pb_dat_i[i] : pa_dat_i[i]);
    assign pad_oe_o[i] = own_i[i] ? oe_i[i]  : (sel_i[i] ? pb_oe_i[i]  : pa_oe_i[i]);
    assign pa_in_o[i]  = fwd & ~sel_i[i];
    assign pb_in_o[i]  = fwd &  sel_i[i];
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int BUS_AW   = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [BUS_AW-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  input  logic                we_i,
  input  logic                re_i,
  output logic [NUM_PINS-1:0] rdata_o,
  output logic                irq_o,
  input  logic [NUM_PINS-1:0] pad_i,
  input  logic [NUM_PINS-1:0] pad_unk_i,
  output logic [NUM_PINS-1:0] pad_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  input  logic [NUM_PINS-1:0] per_a_dat_i,
  input  logic [NUM_PINS-1:0] per_a_oe_i,
  input  logic [NUM_PINS-1:0] per_b_dat_i,
  input  logic [NUM_PINS-1:0] per_b_oe_i,
  output logic [NUM_PINS-1:0] per_a_in_o,
  output logic [NUM_PINS-1:0] per_b_in_o
);
  localparam int NP = NUM_PINS;

  logic [WIN_AW-1:0] ofs;
  logic              unused_addr_hi;
  assign ofs            = addr_i[WIN_AW-1:0];
  assign unused_addr_hi = ^addr_i[BUS_AW-1:WIN_AW];

  // configuration masks
  logic [NP-1:0] mask_q [NUM_MASKS];
  for (genvar k = 0; k < NUM_MASKS; k++) begin : g_mask
    gpio_mask_reg #(.W(NP), .RST_ONES(k == MK_OWN)) u_mask (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (we_i && (ofs == OFS_SET[k])),
      .clr_i (we_i && (ofs == OFS_CLR[k])),
      .val_i (wdata_i),
      .q_o   (mask_q[k])
    );
  end

  logic [NP-1:0] own_q, oe_q, wen_q, imr_q, pu_q, sel_q;
  assign own_q = mask_q[MK_OWN];
  assign oe_q  = mask_q[MK_OE];
  assign wen_q = mask_q[MK_WEN];
  assign imr_q = mask_q[MK_IRQ];
  assign pu_q  = mask_q[MK_PU];
  assign sel_q = mask_q[MK_SEL];

  // output data and pad drive level
  logic [NP-1:0] odat_q, drv_q, gate;
  logic          wr_dset, wr_dclr, wr_ddat;
  assign wr_dset = we_i && (ofs == OFS_DSET);
  assign wr_dclr = we_i && (ofs == OFS_DCLR);
  assign wr_ddat = we_i && (ofs == OFS_DDAT);
  assign gate    = own_q & oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      odat_q <= '0;
      drv_q  <= '0;
    end else if (wr_dset) begin
      odat_q <= odat_q | wdata_i;
      drv_q  <= drv_q | (wdata_i & gate);
    end else if (wr_dclr) begin
      odat_q <= odat_q & ~wdata_i;
      drv_q  <= drv_q & ~(wdata_i & gate);
    end else if (wr_ddat) begin
      odat_q <= (odat_q & ~wen_q) | (wdata_i & wen_q);
      drv_q  <= (drv_q & ~wen_q) | (wdata_i & wen_q);
    end
  end

  // input sampling
  logic [NP-1:0] sync_lvl, lvl_q, unk_q, evt;
  gpio_in_sample #(.N(NP)) u_insamp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pad_i (pad_i),
    .unk_i (pad_unk_i),
    .own_i (own_q),
    .oe_i  (oe_q),
    .sync_o(sync_lvl),
    .lvl_o (lvl_q),
    .unk_o (unk_q),
    .evt_o (evt)
  );

  // interrupt status: a new event outranks the clearing read
  logic [NP-1:0] isr_q;
  logic          rd_isr;
  assign rd_isr = re_i && (ofs == OFS_ISR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= (rd_isr ? '0 : isr_q) | evt;
  end

  assign irq_o = |(isr_q & imr_q);

  // pad routing
  gpio_pad_mux #(.N(NP)) u_padmux (
    .own_i   (own_q),
    .oe_i    (oe_q),
    .sel_i   (sel_q),
    .drv_i   (drv_q),
    .sync_i  (sync_lvl),
    .pa_dat_i(per_a_dat_i),
    .pa_oe_i (per_a_oe_i),
    .pb_dat_i(per_b_dat_i),
    .pb_oe_i (per_b_oe_i),
    .pad_o   (pad_o),
    .pad_oe_o(pad_oe_o),
    .pa_in_o (per_a_in_o),
    .pb_in_o (per_b_in_o)
  );

  // read mux
  logic [NP-1:0] pin_view, rd_val;
  assign pin_view = (lvl_q & ~unk_q) | (pu_q & unk_q);

  always_comb begin
    rd_val = '0;
    for (int k = 0; k < NUM_MASKS; k++) begin
      if (ofs == OFS_STS[k]) rd_val = mask_q[k];
    end
    case (ofs)
      OFS_DDAT: rd_val = odat_q;
      OFS_PINS: rd_val = pin_view;
      OFS_ISR:  rd_val = isr_q;
      default:  ;
    endcase
  end

  assign rdata_o = re_i ? rd_val : '0;
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [WIN_AW-1:0]   ofs_i,
  input logic                we_i,
  input logic                re_i,
  input logic                irq_o,
  input logic [NUM_PINS-1:0] own_q,
  input logic [NUM_PINS-1:0] oe_q,
  input logic [NUM_PINS-1:0] imr_q,
  input logic [NUM_PINS-1:0] drv_q,
  input logic [NUM_PINS-1:0] lvl_q,
  input logic [NUM_PINS-1:0] isr_q,
  input logic [NUM_PINS-1:0] evt
);
  function automatic logic listed(input logic [WIN_AW-1:0] o);
    logic hit;
    hit = (o == OFS_DSET) || (o == OFS_DCLR) || (o == OFS_DDAT) ||
          (o == OFS_PINS) || (o == OFS_ISR);
    for (int k = 0; k < NUM_MASKS; k++)
      hit = hit || (o == OFS_SET[k]) || (o == OFS_CLR[k]) || (o == OFS_STS[k]);
    return hit;
  endfunction

  logic wr_data;
  assign wr_data = we_i && ((ofs_i == OFS_DSET) || (ofs_i == OFS_DCLR));

  AST_UNLISTED_WR_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !listed(ofs_i)) |=> ($stable(own_q) && $stable(oe_q) && $stable(imr_q) && $stable(drv_q))); // R2

  AST_DRV_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data |=> (((drv_q ^ $past(drv_q)) & ~$past(own_q & oe_q)) == '0)); // R5

  AST_OE_FREEZES_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (((lvl_q ^ $past(lvl_q)) & $past(oe_q)) == '0)); // R8

  AST_ISR_ONLY_FROM_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (((isr_q & ~$past(isr_q)) & ~$past(evt)) == '0)); // R8

  AST_EVENT_NOT_LOST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt) |=> ((isr_q & $past(evt)) == $past(evt))); // R11

  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && (ofs_i == OFS_ISR) && !(|evt)) |=> ((isr_q == '0) && !irq_o)); // R11

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imr_q == '0) |-> !irq_o); // R10
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .ofs_i (addr_i[gpio_port_pkg::WIN_AW-1:0]),
  .we_i  (we_i),
  .re_i  (re_i),
  .irq_o (irq_o),
  .own_q (own_q),
  .oe_q  (oe_q),
  .imr_q (imr_q),
  .drv_q (drv_q),
  .lvl_q (lvl_q),
  .isr_q (isr_q),
  .evt   (evt)
);

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] rdata;
  logic        irq;
  logic [31:0] pad_r = '0, unk_r = '0;
  logic [31:0] pad_o, pad_oe_o, pa_in, pb_in;
  logic [31:0] pa_dat = 32'h3C5A_96E1, pa_oe = 32'h0FF0_33CC;
  logic [31:0] pb_dat = 32'hC3A5_691E, pb_oe = 32'hF00F_CC33;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // reference state
  logic [31:0] m_own, m_oe, m_flt, m_md, m_wen, m_imr, m_pu, m_sel;
  logic [31:0] m_odat, m_drv, m_lvl, m_unk, m_isr;

  always #5 clk = ~clk;

  gpio_port_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .irq_o(irq),
    .pad_i(pad_r), .pad_unk_i(unk_r), .pad_o(pad_o), .pad_oe_o(pad_oe_o),
    .per_a_dat_i(pa_dat), .per_a_oe_i(pa_oe), .per_b_dat_i(pb_dat), .per_b_oe_i(pb_oe),
    .per_a_in_o(pa_in), .per_b_in_o(pb_in)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic model_reset();
    m_own = '1; m_oe = '0; m_flt = '0; m_md = '0; m_wen = '0; m_imr = '0;
    m_pu = '0; m_sel = '0; m_odat = '0; m_drv = '0; m_lvl = '0; m_unk = '1; m_isr = '0;
  endtask

  task automatic model_sample();
    logic [31:0] upd, nl;
    upd   = m_own & ~m_oe;
    nl    = pad_r & ~unk_r;
    m_isr = m_isr | (upd & (nl ^ m_lvl));
    m_lvl = (m_lvl & ~upd) | (nl & upd);
    m_unk = (m_unk & ~upd) | (unk_r & upd);
  endtask

  task automatic model_write(input logic [8:0] o, input logic [31:0] d);
    logic [31:0] g;
    g = m_own & m_oe;
    case (o)
      9'h000: m_own |= d;   9'h004: m_own &= ~d;
      9'h010: m_oe  |= d;   9'h014: m_oe  &= ~d;
      9'h020: m_flt |= d;   9'h024: m_flt &= ~d;
      9'h050: m_md  |= d;   9'h054: m_md  &= ~d;
      9'h0A0: m_wen |= d;   9'h0A4: m_wen &= ~d;
      9'h040: m_imr |= d;   9'h044: m_imr &= ~d;
      9'h064: m_pu  |= d;   9'h060: m_pu  &= ~d;
      9'h074: m_sel |= d;   9'h070: m_sel &= ~d;
      9'h030: begin m_odat |= d; m_drv |= d & g; end
      9'h034: begin m_odat &= ~d; m_drv &= ~(d & g); end
      9'h038: begin
        m_odat = (m_odat & ~m_wen) | (d & m_wen);
        m_drv  = (m_drv & ~m_wen) | (d & m_wen);
      end
      default: ;
    endcase
  endtask

  function automatic logic [31:0] model_read(input logic [8:0] o);
    case (o)
      9'h008: return m_own;
      9'h018: return m_oe;
      9'h028: return m_flt;
      9'h058: return m_md;
      9'h0A8: return m_wen;
      9'h048: return m_imr;
      9'h068: return m_pu;
      9'h078: return m_sel;
      9'h038: return m_odat;
      9'h03C: return (m_lvl & ~m_unk) | (m_pu & m_unk);
      9'h04C: return m_isr;
      default: return '0;
    endcase
  endfunction

  // all bus tasks start and end at a falling edge
  task automatic do_write(input logic [31:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    model_write(a[8:0], d);
    @(negedge clk);
    model_sample();
  endtask

  task automatic do_read(input logic [31:0] a, input string tag);
    addr = a; re = 1'b1;
    #1;
    chk(tag, $sformatf("read @%03h", a[8:0]), rdata, model_read(a[8:0]));
    @(negedge clk);
    re = 1'b0;
    if (a[8:0] == 9'h04C) m_isr = '0;
    @(negedge clk);
    model_sample();
  endtask

  task automatic set_pads(input logic [31:0] p, input logic [31:0] u);
    pad_r = p; unk_r = u;
    repeat (4) @(negedge clk);
    model_sample();
  endtask

  task automatic chk_outs(input string tag);
    logic [31:0] ep, eo, fwd;
    ep  = (m_own & m_drv) | (~m_own & ((m_sel & pb_dat) | (~m_sel & pa_dat)));
    eo  = (m_own & m_oe)  | (~m_own & ((m_sel & pb_oe)  | (~m_sel & pa_oe)));
    fwd = ~m_own & ~m_oe & pad_r;
    chk(tag, "pad_o", pad_o, ep);
    chk(tag, "pad_oe_o", pad_oe_o, eo);
    chk(tag, "per_a_in_o", pa_in, fwd & ~m_sel);
    chk(tag, "per_b_in_o", pb_in, fwd & m_sel);
    chk(tag, "irq_o", {31'b0, irq}, {31'b0, |(m_isr & m_imr)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL all requirements: watchdog expired, actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    do_read(32'h008, "R1");
    do_read(32'h018, "R1");
    do_read(32'h04C, "R1");
    do_read(32'h078, "R1");
    do_read(32'h038, "R1");
    do_read(32'h03C, "R1");
    chk_outs("R1");
    set_pads('0, '0);

    // R3 set/clear/status triplets
    do_write(32'h010, 32'h0000_00FF); do_read(32'h018, "R3");
    do_write(32'h014, 32'h0000_000F); do_read(32'h018, "R3");
    do_write(32'h020, 32'hF0F0_0000); do_read(32'h028, "R3");
    do_write(32'h050, 32'h0000_1234); do_write(32'h054, 32'h0000_0204); do_read(32'h058, "R3");
    do_write(32'h0A0, 32'h0000_FF00); do_read(32'h0A8, "R3");

    // R4 inverted-polarity pairs
    do_write(32'h064, 32'h0300_0000); do_write(32'h060, 32'h0100_0000); do_read(32'h068, "R4");
    do_write(32'h074, 32'h00F0_0000); do_write(32'h070, 32'h0030_0000); do_read(32'h078, "R4");

    // R2 aliasing and unlisted offsets
    do_read(32'h1234_0208, "R2");
    do_write(32'h00C, 32'hFFFF_FFFF);
    do_write(32'h1FC, 32'hFFFF_FFFF);
    do_write(32'h032, 32'hFFFF_FFFF);
    do_read(32'h00C, "R2");
    do_read(32'h018, "R2");
    do_read(32'h038, "R2");
    chk_outs("R2");

    // R5 set/clear data with drive gating
    do_write(32'h030, 32'h0000_FFFF); chk_outs("R5"); do_read(32'h038, "R5");
    do_write(32'h034, 32'h0000_0030); chk_outs("R5"); do_read(32'h038, "R5");

    // R6 direct write through the enable mask
    do_write(32'h038, 32'hAAAA_5555); do_read(32'h038, "R6"); chk_outs("R6");

    // R7 peripheral routing
    do_write(32'h004, 32'h00FF_0000); chk_outs("R7");

    // R12 input forwarding
    set_pads(32'h00FF_0000, '0); chk_outs("R12");

    // R8 / R10 / R11 event, mask and clear-on-read
    do_write(32'h040, 32'h0100_0000); do_read(32'h048, "R10");
    set_pads(32'h01FF_0000, '0); chk_outs("R10");
    do_read(32'h04C, "R11"); chk_outs("R11"); do_read(32'h04C, "R11");
    set_pads(32'h01FF_0010, '0); do_read(32'h03C, "R8"); do_read(32'h04C, "R8");

    // R9 floating pins fall back to pull-up
    set_pads(32'h01FF_0010, 32'h0600_0000); do_read(32'h03C, "R9");
    set_pads(32'h07FF_0010, '0); do_read(32'h03C, "R9"); do_read(32'h04C, "R9");

    // R11 event on the same edge as the clearing read
    pad_r = pad_r | 32'h0800_0000;
    @(negedge clk); @(negedge clk);
    do_read(32'h04C, "R11");
    do_read(32'h04C, "R11");
    chk_outs("R11");

    // constrained random
    void'($urandom(32'h5EED_0042));
    for (int it = 0; it < 400; it++) begin
      logic [31:0] a;
      int op;
      op = int'($urandom % 5);
      a  = {$urandom, 9'h0} | {23'h0, 9'($urandom % 128) << 2};
      case (op)
        0, 1: do_write(a, $urandom);
        2:    do_read(a, "R3");
        3:    set_pads($urandom, $urandom & 32'h0F0F_0F0F);
        default: begin
          do_read(32'h03C, "R9");
          do_read(32'h04C, "R11");
        end
      endcase
      chk_outs("R7");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule